// File: doc/BRIEF.md
# Fractional Divider Parameter Encoder

This block takes a divide ratio written as a whole part `a` plus a fraction `b/c` and turns it into three register parameters for a fractional clock divider. It also decides whether the ratio is one the divider can use. The whole part carries a fixed offset. The second parameter holds the remainder left after the fraction is scaled by 128, and the third is the denominator itself. The scaled quotient `floor(128*b/c)` comes from a restoring shift-subtract divider that produces one quotient bit per clock. After the last step the block raises either a valid flag or an error flag.

Two divider classes are supported. The general class takes fractional ratios. The restricted class takes only even integers in a narrow band. A flag latched with the start strobe picks the class.

The second half of the block is a byte-wide parameter store. Software loads the encoded parameters one byte at a time into a shadow copy. The divider's active parameters change only when one particular byte is written: the least-significant byte of the second parameter. That write moves every shadow byte into the active set in a single cycle, so the divider never runs on a mix of old and new bytes.

Top module: `frac_div_encoder`

## Requirements
- R1: When valid, `p1_o` equals `(128*a + floor(128*b/c) - 512)` taken modulo 2^18.
- R2: When valid, `p2_o` equals `128*b - c*floor(128*b/c)` and `p3_o` equals `c`.
- R3: A start is accepted when `start_i` is high and no computation is running. The edge that accepts it captures a, b, c and the class flag, and clears both `valid_o` and `err_o`. Exactly 8 clock edges after that edge, exactly one of the two flags becomes 1. The two flags are never high together.
- R4: A start pulse while a computation is running is ignored. The result reflects the operands of the accepted start.
- R5: If `c` is zero, or if `b` is not less than `c`, the result is an error.
- R6: General class (`int_only_i`=0): the ratio is legal only if it is exactly 6, or if it lies in the range 8 to 2050 inclusive. A whole part of 2050 is legal only with `b`=0.
- R7: Restricted class (`int_only_i`=1): the ratio is legal only if `b` is 0 and `a` is an even integer from 6 to 254 inclusive.
- R8: A write with `wr_en_i`=1 stores `wr_byte_i` in shadow byte `wr_idx_i`. The layout is as follows. Bytes 0..2 hold parameter 1, least-significant byte first. Bytes 3..5 hold parameter 2 in the same order. Bytes 6..8 hold parameter 3 in the same order. Indices 9 to 15 are ignored.
- R9: A write to any index other than 3 leaves `act_p1_o`, `act_p2_o` and `act_p3_o` unchanged.
- R10: A write to index 3 updates all three active outputs on that same edge. They take the full shadow contents, including the byte being written.
- R11: After reset all outputs are zero and the shadow store is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for one encoding |
| int_only_i | input | 1 | Selects the restricted, even-integer divider class |
| ratio_a_i | input | 12 | Whole part of the ratio |
| ratio_b_i | input | 20 | Fraction numerator |
| ratio_c_i | input | 20 | Fraction denominator |
| p1_o | output | 18 | Encoded parameter 1 |
| p2_o | output | 20 | Encoded parameter 2 (scaled remainder) |
| p3_o | output | 20 | Encoded parameter 3 (denominator) |
| valid_o | output | 1 | Result is legal and ready |
| err_o | output | 1 | Ratio rejected |
| wr_en_i | input | 1 | Shadow byte write enable |
| wr_idx_i | input | 4 | Shadow byte index |
| wr_byte_i | input | 8 | Shadow byte data |
| act_p1_o | output | 18 | Active parameter 1 |
| act_p2_o | output | 20 | Active parameter 2 |
| act_p3_o | output | 20 | Active parameter 3 |

## Verification
The assertions assume reset is applied before any stimulus. They also assume the operands are simply sampled on the accepting edge, so nothing is required of them after that edge. The remainder-below-denominator property depends on a correct legality check; it places no restriction on what the stimulus may present. The bench drives every input at the falling edge and pulses start only when the block is idle, except for the one scenario that deliberately pulses it mid-computation. That keeps each result tied to a single accepted operand set.

// File: rtl/fde_pkg.sv
package fde_pkg;
    localparam int GEN_SINGLE = 6;
    localparam int GEN_LOW    = 8;
    localparam int GEN_HIGH   = 2050;
    localparam int INT_LOW    = 6;
    localparam int INT_HIGH   = 254;
    localparam int P1_BIAS    = 512;

    function automatic int bytes_for(input int width);
        return (width + 7) / 8;
    endfunction
endpackage

// File: rtl/fde_range_check.sv
module fde_range_check #(
    parameter int A_W = 12,
    parameter int R_W = 20
) (
    input  logic [A_W-1:0] whole_i,
    input  logic [R_W-1:0] num_i,
    input  logic [R_W-1:0] den_i,
    input  logic           int_only_i,
    output logic           legal_o
);
    import fde_pkg::*;

    logic frac_ok;
    logic gen_ok;
    logic int_ok;

    always_comb begin
        frac_ok = (den_i != '0) && (num_i < den_i);
        gen_ok  = ((num_i == '0) && (whole_i == A_W'(GEN_SINGLE)))
               || ((whole_i >= A_W'(GEN_LOW)) && (whole_i < A_W'(GEN_HIGH)))
               || ((num_i == '0) && (whole_i == A_W'(GEN_HIGH)));
        int_ok  = (num_i == '0) && !whole_i[0]
               && (whole_i >= A_W'(INT_LOW)) && (whole_i <= A_W'(INT_HIGH));
        legal_o = frac_ok && (int_only_i ? int_ok : gen_ok);
    end
endmodule

// File: rtl/fde_long_div.sv
module fde_long_div #(
    parameter int R_W       = 20,
    parameter int FRAC_BITS = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [R_W-1:0]       num_i,
    input  logic [R_W-1:0]       den_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [FRAC_BITS-1:0] quot_o,
    output logic [R_W-1:0]       rem_o
);
    localparam int CNT_W = $clog2(FRAC_BITS + 1);

    typedef struct packed {
        logic                 busy;
        logic                 done;
        logic [CNT_W-1:0]     cnt;
        logic [R_W:0]         rem;
        logic [R_W-1:0]       den;
        logic [FRAC_BITS-1:0] quot;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [R_W:0] shifted;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        shifted   = {st_q.rem[R_W-1:0], 1'b0};
        if (st_q.busy) begin
            if (shifted >= {1'b0, st_q.den}) begin
                st_d.rem  = shifted - {1'b0, st_q.den};
                st_d.quot = {st_q.quot[FRAC_BITS-2:0], 1'b1};
            end else begin
                st_d.rem  = shifted;
                st_d.quot = {st_q.quot[FRAC_BITS-2:0], 1'b0};
            end
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == CNT_W'(FRAC_BITS - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.rem  = {1'b0, num_i};
            st_d.den  = den_i;
            st_d.quot = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign quot_o = st_q.quot;
    assign rem_o  = st_q.rem[R_W-1:0];
endmodule

// File: rtl/fde_param_shadow.sv
module fde_param_shadow #(
    parameter int P1_W  = 18,
    parameter int R_W   = 20,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [7:0]       wr_byte_i,
    output logic [P1_W-1:0]  act_p1_o,
    output logic [R_W-1:0]   act_p2_o,
    output logic [R_W-1:0]   act_p3_o
);
    import fde_pkg::*;

    localparam int P1_BYTES  = bytes_for(P1_W);
    localparam int R_BYTES   = bytes_for(R_W);
    localparam int NUM_BYTES = P1_BYTES + 2 * R_BYTES;
    localparam int COMMIT_AT = P1_BYTES;
    localparam int P2_LSB    = 8 * P1_BYTES;
    localparam int P3_LSB    = 8 * (P1_BYTES + R_BYTES);

    typedef struct packed {
        logic [8*NUM_BYTES-1:0] shadow;
        logic [8*NUM_BYTES-1:0] active;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (wr_en_i && (wr_idx_i == IDX_W'(i)))
                st_d.shadow[8*i +: 8] = wr_byte_i;
        end
        if (wr_en_i && (wr_idx_i == IDX_W'(COMMIT_AT)))
            st_d.active = st_d.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_p1_o = st_q.active[P1_W-1:0];
    assign act_p2_o = st_q.active[P2_LSB +: R_W];
    assign act_p3_o = st_q.active[P3_LSB +: R_W];
endmodule

// File: rtl/frac_div_encoder.sv
module frac_div_encoder #(
    parameter int A_W       = 12,
    parameter int R_W       = 20,
    parameter int P1_W      = 18,
    parameter int FRAC_BITS = 7,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             int_only_i,
    input  logic [A_W-1:0]   ratio_a_i,
    input  logic [R_W-1:0]   ratio_b_i,
    input  logic [R_W-1:0]   ratio_c_i,
    output logic [P1_W-1:0]  p1_o,
    output logic [R_W-1:0]   p2_o,
    output logic [R_W-1:0]   p3_o,
    output logic             valid_o,
    output logic             err_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [7:0]       wr_byte_i,
    output logic [P1_W-1:0]  act_p1_o,
    output logic [R_W-1:0]   act_p2_o,
    output logic [R_W-1:0]   act_p3_o
);
    import fde_pkg::*;

    localparam int SUM_W = A_W + FRAC_BITS + 1;

    typedef struct packed {
        logic [A_W-1:0]  a;
        logic [R_W-1:0]  b;
        logic [R_W-1:0]  c;
        logic            io;
        logic [P1_W-1:0] p1;
        logic [R_W-1:0]  p2;
        logic [R_W-1:0]  p3;
        logic            valid;
        logic            err;
    } enc_st_t;

    enc_st_t st_d, st_q;

    logic                 div_busy;
    logic                 div_done;
    logic [FRAC_BITS-1:0] div_quot;
    logic [R_W-1:0]       div_rem;
    logic                 legal;
    logic                 accept;
    logic [SUM_W-1:0]     p1_sum;

    assign accept = start_i && !div_busy;

    fde_long_div #(.R_W(R_W), .FRAC_BITS(FRAC_BITS)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .num_i  (ratio_b_i),
        .den_i  (ratio_c_i),
        .busy_o (div_busy),
        .done_o (div_done),
        .quot_o (div_quot),
        .rem_o  (div_rem)
    );

    fde_range_check #(.A_W(A_W), .R_W(R_W)) u_range (
        .whole_i   (st_q.a),
        .num_i     (st_q.b),
        .den_i     (st_q.c),
        .int_only_i(st_q.io),
        .legal_o   (legal)
    );

    fde_param_shadow #(.P1_W(P1_W), .R_W(R_W), .IDX_W(IDX_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wr_idx_i (wr_idx_i),
        .wr_byte_i(wr_byte_i),
        .act_p1_o (act_p1_o),
        .act_p2_o (act_p2_o),
        .act_p3_o (act_p3_o)
    );

    always_comb begin
        st_d   = st_q;
        p1_sum = SUM_W'({st_q.a, {FRAC_BITS{1'b0}}}) + SUM_W'(div_quot) - SUM_W'(P1_BIAS);
        if (div_done) begin
            st_d.p1    = p1_sum[P1_W-1:0];
            st_d.p2    = div_rem;
            st_d.p3    = st_q.c;
            st_d.valid = legal;
            st_d.err   = !legal;
        end
        if (accept) begin
            st_d.a     = ratio_a_i;
            st_d.b     = ratio_b_i;
            st_d.c     = ratio_c_i;
            st_d.io    = int_only_i;
            st_d.valid = 1'b0;
            st_d.err   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign p1_o    = st_q.p1;
    assign p2_o    = st_q.p2;
    assign p3_o    = st_q.p3;
    assign valid_o = st_q.valid;
    assign err_o   = st_q.err;
endmodule

// File: rtl/fde_encoder_chk.sv
module fde_encoder_chk #(
    parameter int P1_W      = 18,
    parameter int R_W       = 20,
    parameter int IDX_W     = 4,
    parameter int COMMIT_AT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy,
    input logic             valid_o,
    input logic             err_o,
    input logic [R_W-1:0]   p2_o,
    input logic [R_W-1:0]   p3_o,
    input logic             wr_en_i,
    input logic [IDX_W-1:0] wr_idx_i,
    input logic [7:0]       wr_byte_i,
    input logic [P1_W-1:0]  act_p1_o,
    input logic [R_W-1:0]   act_p2_o,
    input logic [R_W-1:0]   act_p3_o
);
    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));

    assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> (!valid_o && !err_o));

    assert_rem_below_den_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (p2_o < p3_o));

    assert_active_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && (wr_idx_i == IDX_W'(COMMIT_AT)))
        |=> ($stable(act_p1_o) && $stable(act_p2_o) && $stable(act_p3_o)));

    assert_commit_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_idx_i == IDX_W'(COMMIT_AT)))
        |=> (act_p2_o[7:0] == $past(wr_byte_i)));
endmodule

bind frac_div_encoder fde_encoder_chk #(
    .P1_W(P1_W), .R_W(R_W), .IDX_W(IDX_W), .COMMIT_AT(fde_pkg::bytes_for(P1_W))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy     (div_busy),
    .valid_o  (valid_o),
    .err_o    (err_o),
    .p2_o     (p2_o),
    .p3_o     (p3_o),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_byte_i(wr_byte_i),
    .act_p1_o (act_p1_o),
    .act_p2_o (act_p2_o),
    .act_p3_o (act_p3_o)
);

// File: tb/frac_div_encoder_bench.sv
`timescale 1ns/1ps
module frac_div_encoder_bench;
    localparam int FB = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        int_only_i = 1'b0;
    logic [11:0] ratio_a_i = '0;
    logic [19:0] ratio_b_i = '0;
    logic [19:0] ratio_c_i = '0;
    logic [17:0] p1_o;
    logic [19:0] p2_o;
    logic [19:0] p3_o;
    logic        valid_o;
    logic        err_o;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_idx_i = '0;
    logic [7:0]  wr_byte_i = '0;
    logic [17:0] act_p1_o;
    logic [19:0] act_p2_o;
    logic [19:0] act_p3_o;

    int vectors = 0;
    int misses = 0;
    bit finished = 1'b0;
    logic [7:0] model [9];

    always #10 clk = ~clk;

    frac_div_encoder u_frac_div_encoder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .int_only_i(int_only_i),
        .ratio_a_i(ratio_a_i), .ratio_b_i(ratio_b_i), .ratio_c_i(ratio_c_i),
        .p1_o(p1_o), .p2_o(p2_o), .p3_o(p3_o), .valid_o(valid_o), .err_o(err_o),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_byte_i(wr_byte_i),
        .act_p1_o(act_p1_o), .act_p2_o(act_p2_o), .act_p3_o(act_p3_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        check(p1_o == 0 && p2_o == 0 && p3_o == 0, "R11 params", p1_o, 0);
        check(!valid_o && !err_o, "R11 flags", {valid_o, err_o}, 0);
        check(act_p1_o == 0 && act_p2_o == 0 && act_p3_o == 0, "R11 active", act_p2_o, 0);
    endtask

    // Runs one encoding; optionally pulses start with other operands mid-run (R4).
    task automatic t_encode(input int a, input int b, input int c, input bit io,
                            input bit exp_ok, input string req, input bit interfere);
        longint q, e1, e2;
        @(negedge clk);
        ratio_a_i = 12'(a); ratio_b_i = 20'(b); ratio_c_i = 20'(c);
        int_only_i = io; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!valid_o && !err_o, "R3 cleared on start", {valid_o, err_o}, 0);
        for (int k = 1; k < FB; k++) begin
            @(negedge clk);
            if (interfere && k == 2) begin
                ratio_a_i = 12'd100; ratio_b_i = 20'd1; ratio_c_i = 20'd7;
                int_only_i = 1'b0; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
        end
        @(negedge clk);
        start_i = 1'b0;
        check(!valid_o && !err_o, "R3 not early", {valid_o, err_o}, 0);
        @(negedge clk);
        check(valid_o == exp_ok && err_o == !exp_ok, req, {valid_o, err_o}, {exp_ok, !exp_ok});
        if (exp_ok) begin
            q  = (128 * longint'(b)) / c;
            e1 = (128 * longint'(a) + q - 512) & 64'h3FFFF;
            e2 = 128 * longint'(b) - longint'(c) * q;
            check(p1_o == e1, interfere ? "R4 p1" : "R1 p1", p1_o, e1);
            check(p2_o == e2, "R2 p2", p2_o, e2);
            check(p3_o == c, "R2 p3", p3_o, c);
        end
    endtask

    task automatic t_example();
        t_encode(32, 96, 125, 1'b0, 1'b1, "R6 example legal", 1'b0);
        check(p1_o == 18'hE62, "R1 example p1", p1_o, 3682);
        check(p2_o == 20'h26 && p3_o == 20'h7D, "R2 example p2/p3", p2_o, 38);
    endtask

    task automatic wr(input int idx, input int data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_idx_i = 4'(idx); wr_byte_i = 8'(data);
        @(negedge clk);
        wr_en_i = 1'b0;
        if (idx < 9) model[idx] = 8'(data);
    endtask

    function automatic longint mp(input int base, input longint mask);
        return {model[base+2], model[base+1], model[base]} & mask;
    endfunction

    task automatic t_shadow();
        longint o1, o2, o3;
        for (int i = 0; i < 9; i++) model[i] = '0;
        wr(3, 8'h11);
        o1 = mp(0, 64'h3FFFF); o2 = mp(3, 64'hFFFFF); o3 = mp(6, 64'hFFFFF);
        check(act_p2_o == o2, "R10 first commit", act_p2_o, o2);
        for (int i = 0; i < 9; i++) if (i != 3) wr(i, 8'hA0 + i);
        check(act_p1_o == o1 && act_p2_o == o2 && act_p3_o == o3, "R9 held p2", act_p2_o, o2);
        check(act_p3_o == o3, "R9 held p3", act_p3_o, o3);
        wr(12, 8'h5A);
        wr(3, 8'h3C);
        o1 = mp(0, 64'h3FFFF); o2 = mp(3, 64'hFFFFF); o3 = mp(6, 64'hFFFFF);
        check(act_p1_o == o1, "R10 p1 commit", act_p1_o, o1);
        check(act_p2_o == o2, "R8 R10 p2 commit", act_p2_o, o2);
        check(act_p3_o == o3, "R8 p3 commit idx12 ignored", act_p3_o, o3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_example();
        t_encode(6, 0, 1, 1'b0, 1'b1, "R6 exact 6", 1'b0);
        t_encode(6, 1, 2, 1'b0, 1'b0, "R6 fraction above 6", 1'b0);
        t_encode(7, 0, 1, 1'b0, 1'b0, "R6 seven", 1'b0);
        t_encode(8, 0, 3, 1'b0, 1'b1, "R6 eight", 1'b0);
        t_encode(2049, 999999, 1000000, 1'b0, 1'b1, "R6 top fraction", 1'b0);
        t_encode(2050, 0, 5, 1'b0, 1'b1, "R6 2050", 1'b0);
        t_encode(2050, 1, 2, 1'b0, 1'b0, "R6 above 2050", 1'b0);
        t_encode(40, 3, 0, 1'b0, 1'b0, "R5 zero c", 1'b0);
        t_encode(40, 9, 9, 1'b0, 1'b0, "R5 b equals c", 1'b0);
        t_encode(6, 0, 1, 1'b1, 1'b1, "R7 six", 1'b0);
        t_encode(254, 0, 1, 1'b1, 1'b1, "R7 254", 1'b0);
        t_encode(256, 0, 1, 1'b1, 1'b0, "R7 256", 1'b0);
        t_encode(7, 0, 1, 1'b1, 1'b0, "R7 odd", 1'b0);
        t_encode(4, 0, 1, 1'b1, 1'b0, "R7 four", 1'b0);
        t_encode(100, 1, 3, 1'b1, 1'b0, "R7 fraction", 1'b0);
        t_encode(517, 77, 333, 1'b0, 1'b1, "R4 busy start ignored", 1'b1);
        t_shadow();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL R3 watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule